// File: doc/BRIEF.md
# Protection Tuple Checker

This block checks end-to-end protection information on a stream of logical blocks. Each block arrives one byte per accepted cycle: first the data bytes, then the metadata bytes. The metadata holds an eight-byte tuple made of a 16-bit guard, a 16-bit application tag and a 32-bit reference tag, all most-significant byte first. The tuple sits either at the start or at the end of the metadata. The checker recomputes the guard CRC for every block and compares the tuple with the values that came with the command. It reports a single status code when the command finishes.

A command is loaded in one cycle while the block is idle. The command carries the enabled checks, the protection type, the tuple placement, the expected application tag and its mask, the initial reference tag, the low word of the starting block address and the block count. The checker records the first failure and stops evaluating after it. It still consumes every remaining byte of the command, so the stream stays aligned for the next command.

Top module: `pi_tuple_checker`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done` and `status` are all 0.
- R2: When a command is accepted with type 1 (`cmd_pi_type` = 1), reference checking enabled (`cmd_chk[0]` = 1) and `cmd_ref_tag` different from `cmd_slba_lo`, the command ends with status 1. This result wins over any block result. Types 2 and 3 never fail this check.
- R3: For types 1 and 2, a block whose stored application tag is 0xFFFF passes with no checks applied. A value of 0 on `cmd_pi_type` is handled as type 2.
- R4: For type 3, a block is skipped only when its stored application tag is 0xFFFF and its stored reference tag is 0xFFFFFFFF. A block with only the application tag at 0xFFFF is still checked.
- R5: Within a block the checks run in a fixed order: guard, then application tag, then reference tag. The first mismatch sets the status: 2 for guard, 3 for application tag, 4 for reference tag. Success is 0.
- R6: The application tag check compares only the bits set in `cmd_app_mask`: (stored AND mask) must equal (expected AND mask).
- R7: The guard is a CRC-16 with polynomial 0x8BB7, initial value 0, processed MSB first with no reflection. It covers the data bytes and then the metadata bytes in front of the tuple. With `cmd_tuple_first` = 1 the tuple occupies metadata bytes 0..7. With `cmd_tuple_first` = 0 it occupies the last eight metadata bytes. The guard is stored in the first two tuple bytes, then the application tag in the next two, then the reference tag in the last four, each MSB first.
- R8: For types 1 and 2 the expected reference tag rises by one after every block, skipped blocks included. For type 3 it stays at `cmd_ref_tag`.
- R9: Only the first failing block sets the status. Later blocks of the same command cannot change it.
- R10: `done` is high for exactly one cycle, in the cycle after the last byte of block `cmd_nblk` (the count minus one) is accepted. `busy` is low in that cycle. Bytes with `in_valid` low are not consumed.
- R11: `cmd_valid` has no effect while `busy` is high.
- R12: A check whose enable bit is 0 (bit 2 guard, bit 1 application tag, bit 0 reference tag) never produces an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Load a command (taken only when idle) |
| cmd_chk | input | 3 | Check enables: [2] guard, [1] application tag, [0] reference tag |
| cmd_pi_type | input | 2 | Protection type 1, 2 or 3 |
| cmd_tuple_first | input | 1 | 1: tuple at metadata start, 0: tuple at metadata end |
| cmd_app_tag | input | 16 | Expected application tag |
| cmd_app_mask | input | 16 | Application tag compare mask |
| cmd_ref_tag | input | 32 | Initial expected reference tag |
| cmd_slba_lo | input | 32 | Low 32 bits of the starting block address |
| cmd_nblk | input | NBLK_W | Number of blocks minus one |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Stream byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command strobe |
| status | output | 3 | Result code, valid with `done` |

## Verification
The main sweep runs every protection type, both tuple placements and all eight check-enable combinations. Each setting is tried against clean blocks, single faults in the guard, application tag and reference tag, and combined faults. The combined faults show whether priority is applied within a block and whether the first block wins over a later one. Escape patterns with only the application tag at 0xFFFF, or with both tags at all-ones, separate the type 3 rule from the type 1 and 2 rule. A clean block after a skipped one shows whether the reference tag still advanced. Directed runs cover the following:
- mask values that hide or expose a differing byte;
- the up-front address check for type 1 against types 2 and 3;
- long commands with idle gaps in the stream;
- a command request made while the checker is busy.

// File: rtl/pi_chk_pkg.sv
package pi_chk_pkg;

    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_INV   = 3'd1,
        ST_GUARD = 3'd2,
        ST_APP   = 3'd3,
        ST_REF   = 3'd4
    } pi_status_e;

    typedef enum logic [0:0] {
        M_IDLE = 1'b0,
        M_RUN  = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic [15:0] guard;
        logic [15:0] app;
        logic [31:0] ref_tag;
    } pi_tuple_t;

    localparam int TUPLE_BYTES = 8;
    localparam logic [15:0] GUARD_POLY = 16'h8BB7;

endpackage

// File: rtl/pi_crc16_step.sv
module pi_crc16_step #(
    parameter logic [15:0] POLY = 16'h8BB7
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    logic [15:0] acc;

    always_comb begin
        acc = crc_in ^ {data_in, 8'h00};
        for (int k = 0; k < 8; k++) begin
            if (acc[15]) begin
                acc = {acc[14:0], 1'b0} ^ POLY;
            end else begin
                acc = {acc[14:0], 1'b0};
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/pi_block_layout.sv
module pi_block_layout #(
    parameter int BLK_BYTES = 16,
    parameter int MD_BYTES  = 16,
    parameter int POS_W     = 5
) (
    input  logic [POS_W-1:0] pos,
    input  logic             tuple_first,
    input  logic [7:0]       in_byte,
    input  logic [63:0]      tup_q,
    output logic             guard_span,
    output logic             tuple_span,
    output logic             blk_last,
    output logic [63:0]      tup_shift
);
    localparam int SPAN = BLK_BYTES + MD_BYTES;
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SPAN - 1);
    localparam logic [POS_W-1:0] TS_FIRST  = POS_W'(BLK_BYTES);
    localparam logic [POS_W-1:0] TS_LAST   = POS_W'(SPAN - pi_chk_pkg::TUPLE_BYTES);
    localparam logic [POS_W-1:0] TUP_LEN   = POS_W'(pi_chk_pkg::TUPLE_BYTES);

    logic [POS_W-1:0] tuple_start;
    logic [POS_W-1:0] rel;

    always_comb begin
        tuple_start = tuple_first ? TS_FIRST : TS_LAST;
        rel         = pos - tuple_start;
        guard_span  = (pos < tuple_start);
        tuple_span  = (pos >= tuple_start) && (rel < TUP_LEN);
        blk_last    = (pos == LAST_POS);
        tup_shift   = {tup_q[55:0], in_byte};
    end
endmodule

// File: rtl/pi_tuple_verdict.sv
module pi_tuple_verdict
    import pi_chk_pkg::*;
(
    input  pi_tuple_t    tuple,
    input  logic [15:0]  crc,
    input  logic [2:0]   chk,
    input  logic [1:0]   ptype,
    input  logic [15:0]  exp_app,
    input  logic [15:0]  app_mask,
    input  logic [31:0]  exp_ref,
    output pi_status_e   verdict
);
    logic escape;
    logic guard_bad;
    logic app_bad;
    logic ref_bad;

    always_comb begin
        if (ptype == 2'd3) begin
            escape = (tuple.app == 16'hFFFF) && (tuple.ref_tag == 32'hFFFF_FFFF);
        end else begin
            escape = (tuple.app == 16'hFFFF);
        end
        guard_bad = chk[2] && (tuple.guard != crc);
        app_bad   = chk[1] && (((tuple.app ^ exp_app) & app_mask) != 16'h0000);
        ref_bad   = chk[0] && (tuple.ref_tag != exp_ref);

        if (escape) begin
            verdict = ST_OK;
        end else if (guard_bad) begin
            verdict = ST_GUARD;
        end else if (app_bad) begin
            verdict = ST_APP;
        end else if (ref_bad) begin
            verdict = ST_REF;
        end else begin
            verdict = ST_OK;
        end
    end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker
    import pi_chk_pkg::*;
#(
    parameter int BLK_BYTES = 16,
    parameter int MD_BYTES  = 16,
    parameter int NBLK_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_chk,
    input  logic [1:0]        cmd_pi_type,
    input  logic              cmd_tuple_first,
    input  logic [15:0]       cmd_app_tag,
    input  logic [15:0]       cmd_app_mask,
    input  logic [31:0]       cmd_ref_tag,
    input  logic [31:0]       cmd_slba_lo,
    input  logic [NBLK_W-1:0] cmd_nblk,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              busy,
    output logic              done,
    output logic [2:0]        status
);
    localparam int SPAN  = BLK_BYTES + MD_BYTES;
    localparam int POS_W = $clog2(SPAN);

    typedef struct packed {
        run_mode_e         mode;
        logic [POS_W-1:0]  pos;
        logic [NBLK_W-1:0] blk;
        logic [NBLK_W-1:0] nblk;
        logic [15:0]       crc;
        logic [63:0]       tup;
        logic [31:0]       ref_exp;
        logic [2:0]        chk;
        logic [1:0]        ptype;
        logic              first;
        logic [15:0]       app;
        logic [15:0]       mask;
        pi_status_e        status;
        logic              err;
        logic              done;
    } ctx_t;

    ctx_t ctx_d;
    ctx_t ctx_q;

    logic        guard_span;
    logic        tuple_span;
    logic        blk_last;
    logic [63:0] tup_shift;
    logic [15:0] crc_step;
    logic [63:0] tup_next;
    pi_status_e  verdict;
    logic        precheck_bad;

    pi_block_layout #(
        .BLK_BYTES (BLK_BYTES),
        .MD_BYTES  (MD_BYTES),
        .POS_W     (POS_W)
    ) u_layout (
        .pos         (ctx_q.pos),
        .tuple_first (ctx_q.first),
        .in_byte     (in_byte),
        .tup_q       (ctx_q.tup),
        .guard_span  (guard_span),
        .tuple_span  (tuple_span),
        .blk_last    (blk_last),
        .tup_shift   (tup_shift)
    );

    pi_crc16_step #(
        .POLY (GUARD_POLY)
    ) u_crc (
        .crc_in  (ctx_q.crc),
        .data_in (in_byte),
        .crc_out (crc_step)
    );

    assign tup_next = tuple_span ? tup_shift : ctx_q.tup;

    pi_tuple_verdict u_verdict (
        .tuple    (pi_tuple_t'(tup_next)),
        .crc      (ctx_q.crc),
        .chk      (ctx_q.chk),
        .ptype    (ctx_q.ptype),
        .exp_app  (ctx_q.app),
        .app_mask (ctx_q.mask),
        .exp_ref  (ctx_q.ref_exp),
        .verdict  (verdict)
    );

    assign precheck_bad = (cmd_pi_type == 2'd1) && cmd_chk[0] && (cmd_ref_tag != cmd_slba_lo);

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        case (ctx_q.mode)
            M_IDLE: begin
                if (cmd_valid) begin
                    ctx_d.mode    = M_RUN;
                    ctx_d.pos     = '0;
                    ctx_d.blk     = '0;
                    ctx_d.nblk    = cmd_nblk;
                    ctx_d.crc     = 16'h0000;
                    ctx_d.tup     = '0;
                    ctx_d.ref_exp = cmd_ref_tag;
                    ctx_d.chk     = cmd_chk;
                    ctx_d.ptype   = cmd_pi_type;
                    ctx_d.first   = cmd_tuple_first;
                    ctx_d.app     = cmd_app_tag;
                    ctx_d.mask    = cmd_app_mask;
                    ctx_d.err     = precheck_bad;
                    ctx_d.status  = precheck_bad ? ST_INV : ST_OK;
                end
            end
            default: begin
                if (in_valid) begin
                    ctx_d.crc = guard_span ? crc_step : ctx_q.crc;
                    ctx_d.tup = tup_next;
                    if (blk_last) begin
                        if (!ctx_q.err && (verdict != ST_OK)) begin
                            ctx_d.err    = 1'b1;
                            ctx_d.status = verdict;
                        end
                        if (ctx_q.ptype != 2'd3) begin
                            ctx_d.ref_exp = ctx_q.ref_exp + 32'd1;
                        end
                        ctx_d.crc = 16'h0000;
                        ctx_d.pos = '0;
                        if (ctx_q.blk == ctx_q.nblk) begin
                            ctx_d.done = 1'b1;
                            ctx_d.mode = M_IDLE;
                        end else begin
                            ctx_d.blk = ctx_q.blk + NBLK_W'(1);
                        end
                    end else begin
                        ctx_d.pos = ctx_q.pos + POS_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign busy   = (ctx_q.mode == M_RUN);
    assign done   = ctx_q.done;
    assign status = ctx_q.status;

endmodule

// File: rtl/pi_tuple_checker_sva.sv
module pi_tuple_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_chk,
    input logic [1:0]  cmd_pi_type,
    input logic [31:0] cmd_ref_tag,
    input logic [31:0] cmd_slba_lo,
    input logic        busy,
    input logic        done,
    input logic [2:0]  status,
    input logic [1:0]  ptype,
    input logic [31:0] ref_exp
);
    logic pend_inv;
    logic pend_nochk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_inv   <= 1'b0;
            pend_nochk <= 1'b0;
        end else if (cmd_valid && !busy) begin
            pend_inv   <= (cmd_pi_type == 2'd1) && cmd_chk[0] && (cmd_ref_tag != cmd_slba_lo);
            pend_nochk <= (cmd_chk == 3'b000);
        end else if (done) begin
            pend_inv   <= 1'b0;
            pend_nochk <= 1'b0;
        end
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_status_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status <= 3'd4));

    p_precheck_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_inv) |-> (status == 3'd1));

    p_no_checks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_nochk) |-> (status == 3'd0));

    p_ref_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ptype == 2'd3) |=> $stable(ref_exp));

    p_cmd_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(ptype));

endmodule

bind pi_tuple_checker pi_tuple_checker_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_chk     (cmd_chk),
    .cmd_pi_type (cmd_pi_type),
    .cmd_ref_tag (cmd_ref_tag),
    .cmd_slba_lo (cmd_slba_lo),
    .busy        (busy),
    .done        (done),
    .status      (status),
    .ptype       (ctx_q.ptype),
    .ref_exp     (ctx_q.ref_exp)
);

// File: tb/tb_pi_tuple_checker.sv
module tb_pi_tuple_checker;
    localparam int BLK  = 16;
    localparam int MD   = 16;
    localparam int SPAN = BLK + MD;
    localparam int NBW  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic           cmd_valid;
    logic [2:0]     cmd_chk;
    logic [1:0]     cmd_pi_type;
    logic           cmd_tuple_first;
    logic [15:0]    cmd_app_tag;
    logic [15:0]    cmd_app_mask;
    logic [31:0]    cmd_ref_tag;
    logic [31:0]    cmd_slba_lo;
    logic [NBW-1:0] cmd_nblk;
    logic           in_valid;
    logic [7:0]     in_byte;
    logic           busy;
    logic           done;
    logic [2:0]     status;

    pi_tuple_checker #(.BLK_BYTES(BLK), .MD_BYTES(MD), .NBLK_W(NBW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_chk(cmd_chk),
        .cmd_pi_type(cmd_pi_type), .cmd_tuple_first(cmd_tuple_first),
        .cmd_app_tag(cmd_app_tag), .cmd_app_mask(cmd_app_mask),
        .cmd_ref_tag(cmd_ref_tag), .cmd_slba_lo(cmd_slba_lo), .cmd_nblk(cmd_nblk),
        .in_valid(in_valid), .in_byte(in_byte), .busy(busy), .done(done), .status(status)
    );

    int n_checks = 0;
    int n_err = 0;
    logic [7:0]  mem [0:7][0:SPAN-1];
    logic [31:0] lcg = 32'h1357_9BDF;

    task automatic check_eq(string req, string what, longint act, longint expv);
        n_checks++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_bits(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h8BB7) : (r << 1);
        return r;
    endfunction

    function automatic logic [15:0] blk_crc(int b, bit first);
        logic [15:0] c;
        int pil;
        c = 16'h0;
        pil = first ? 0 : MD - 8;
        for (int i = 0; i < BLK + pil; i++) c = crc_bits(c, mem[b][i]);
        return c;
    endfunction

    task automatic fill_block(int b, bit first, logic [15:0] app, logic [31:0] rt, bit bad_guard);
        int t;
        logic [15:0] g;
        for (int i = 0; i < SPAN; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            mem[b][i] = lcg[23:16];
        end
        t = BLK + (first ? 0 : MD - 8);
        g = blk_crc(b, first) ^ (bad_guard ? 16'h0001 : 16'h0000);
        mem[b][t]   = g[15:8];
        mem[b][t+1] = g[7:0];
        mem[b][t+2] = app[15:8];
        mem[b][t+3] = app[7:0];
        mem[b][t+4] = rt[31:24];
        mem[b][t+5] = rt[23:16];
        mem[b][t+6] = rt[15:8];
        mem[b][t+7] = rt[7:0];
    endtask

    function automatic int model(int typ, logic [2:0] chk, bit first, logic [15:0] app,
                                 logic [15:0] mask, logic [31:0] ref0, logic [31:0] slba, int nb);
        logic [31:0] rexp;
        logic [15:0] g, a;
        logic [31:0] r;
        int t;
        bit esc;
        if (typ == 1 && chk[0] && ref0 != slba) return 1;
        rexp = ref0;
        for (int b = 0; b < nb; b++) begin
            t = BLK + (first ? 0 : MD - 8);
            g = {mem[b][t], mem[b][t+1]};
            a = {mem[b][t+2], mem[b][t+3]};
            r = {mem[b][t+4], mem[b][t+5], mem[b][t+6], mem[b][t+7]};
            esc = (typ == 3) ? (a == 16'hFFFF && r == 32'hFFFF_FFFF) : (a == 16'hFFFF);
            if (!esc) begin
                if (chk[2] && g != blk_crc(b, first)) return 2;
                if (chk[1] && ((a & mask) != (app & mask))) return 3;
                if (chk[0] && r != rexp) return 4;
            end
            if (typ != 3) rexp = rexp + 1;
        end
        return 0;
    endfunction

    task automatic run_cmd(int typ, logic [2:0] chk, bit first, logic [15:0] app, logic [15:0] mask,
                           logic [31:0] ref0, logic [31:0] slba, int nb, bit inject, string req);
        int expv;
        expv = model(typ, chk, first, app, mask, ref0, slba, nb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_chk = chk; cmd_pi_type = 2'(typ); cmd_tuple_first = first;
        cmd_app_tag = app; cmd_app_mask = mask; cmd_ref_tag = ref0; cmd_slba_lo = slba;
        cmd_nblk = NBW'(nb - 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int b = 0; b < nb; b++) begin
            if (b % 2 == 1) begin
                in_valid = 1'b0;
                in_byte = 8'hA5;
                @(negedge clk);
            end
            for (int i = 0; i < SPAN; i++) begin
                in_valid = 1'b1;
                in_byte = mem[b][i];
                if (inject && b == 0 && i == 5) begin
                    cmd_valid = 1'b1; cmd_pi_type = 2'd1; cmd_chk = 3'b111;
                    cmd_ref_tag = slba + 32'd7; cmd_nblk = '0;
                end else begin
                    cmd_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        cmd_valid = 1'b0;
        check_eq("R10", "done at end", longint'(done), 1);
        check_eq("R10", "busy at end", longint'(busy), 0);
        check_eq(req, "status", longint'(status), longint'(expv));
        @(negedge clk);
        check_eq("R10", "done one cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] ea;
        logic [31:0] r0;
        string req;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_chk = '0; cmd_pi_type = 2'd1; cmd_tuple_first = 1'b0;
        cmd_app_tag = '0; cmd_app_mask = '0; cmd_ref_tag = '0; cmd_slba_lo = '0; cmd_nblk = '0;
        in_valid = 1'b0; in_byte = '0;
        repeat (3) @(negedge clk);
        check_eq("R1", "busy in reset", longint'(busy), 0);
        check_eq("R1", "done in reset", longint'(done), 0);
        check_eq("R1", "status in reset", longint'(status), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "busy after reset", longint'(busy), 0);
        check_eq("R1", "done after reset", longint'(done), 0);

        ea = 16'h1234;
        r0 = 32'h0000_0100;
        // Sweep: types, placements, all check enables (R12 when bits are 0), fault patterns
        for (int typ = 1; typ <= 3; typ++) begin
            for (int fst = 0; fst < 2; fst++) begin
                for (int chk = 0; chk < 8; chk++) begin
                    for (int pat = 0; pat < 7; pat++) begin
                        for (int b = 0; b < 2; b++) begin
                            logic [31:0] rt;
                            logic [15:0] at;
                            bit bg;
                            rt = (typ == 3) ? r0 : r0 + 32'(b);
                            at = ea;
                            bg = 1'b0;
                            if (b == 1 && pat == 1) bg = 1'b1;
                            if (b == 1 && (pat == 2 || pat == 4)) at = ea ^ 16'h0100;
                            if (b == 1 && pat == 3) rt = rt ^ 32'h1;
                            if (b == 0 && pat == 4) begin
                                bg = 1'b1; at = ea ^ 16'h0100; rt = rt ^ 32'h1;
                            end
                            if (b == 0 && (pat == 5 || pat == 6)) begin
                                bg = 1'b1; at = 16'hFFFF;
                            end
                            if (b == 0 && pat == 6) rt = 32'hFFFF_FFFF;
                            fill_block(b, fst[0], at, rt, bg);
                        end
                        case (pat)
                            0, 1: req = "R7";
                            2, 4: req = "R5";
                            3: req = "R8";
                            5: req = "R3";
                            default: req = "R4";
                        endcase
                        if (chk != 7) req = {req, "/R12"};
                        run_cmd(typ, 3'(chk), fst[0], ea, 16'hFFFF, r0, r0, 2, 1'b0, req);
                    end
                end
            end
        end

        // R6: masked application tag compare
        fill_block(0, 1'b0, 16'h12AB, 32'd9, 1'b0);
        run_cmd(1, 3'b111, 1'b0, 16'h34AB, 16'h00FF, 32'd9, 32'd9, 1, 1'b0, "R6");
        run_cmd(1, 3'b111, 1'b0, 16'h34AB, 16'hFF00, 32'd9, 32'd9, 1, 1'b0, "R6");
        check_eq("R6", "model masked-out", longint'(model(1, 3'b111, 1'b0, 16'h34AB, 16'hFF00, 32'd9, 32'd9, 1)), 3);

        // R2: up-front reference vs address check
        fill_block(0, 1'b1, 16'h0001, 32'd5, 1'b1);
        run_cmd(1, 3'b111, 1'b1, 16'h0001, 16'hFFFF, 32'd5, 32'd6, 1, 1'b0, "R2");
        run_cmd(1, 3'b110, 1'b1, 16'h0001, 16'hFFFF, 32'd5, 32'd6, 1, 1'b0, "R2");
        fill_block(0, 1'b1, 16'h0001, 32'd5, 1'b0);
        run_cmd(2, 3'b111, 1'b1, 16'h0001, 16'hFFFF, 32'd5, 32'd6, 1, 1'b0, "R2");
        run_cmd(3, 3'b111, 1'b1, 16'h0001, 16'hFFFF, 32'd5, 32'd6, 1, 1'b0, "R2");

        // R9: first failing block decides, later faults ignored
        for (int b = 0; b < 4; b++) fill_block(b, 1'b0, 16'h00C3, 32'd40 + 32'(b), b == 3);
        mem[2][BLK + MD - 1] = mem[2][BLK + MD - 1] ^ 8'h10;
        run_cmd(2, 3'b111, 1'b0, 16'h00C3, 16'hFFFF, 32'd40, 32'd40, 4, 1'b0, "R9");
        check_eq("R9", "model first error", longint'(model(2, 3'b111, 1'b0, 16'h00C3, 16'hFFFF, 32'd40, 32'd40, 4)), 4);

        // R10: full-length command with gaps
        for (int b = 0; b < 8; b++) fill_block(b, 1'b1, 16'h7777, 32'hFFFF_FFF9 + 32'(b), 1'b0);
        run_cmd(1, 3'b111, 1'b1, 16'h7777, 16'hFFFF, 32'hFFFF_FFF9, 32'hFFFF_FFF9, 8, 1'b0, "R10");

        // R11: command request while busy has no effect
        for (int b = 0; b < 2; b++) fill_block(b, 1'b0, 16'h4242, 32'd300, 1'b0);
        run_cmd(3, 3'b111, 1'b0, 16'h4242, 16'hFFFF, 32'd300, 32'd300, 2, 1'b1, "R11");
        run_cmd(2, 3'b111, 1'b0, 16'h4242, 16'hFFFF, 32'd300, 32'd300, 2, 1'b1, "R11");

        // R12: all checks off with every field corrupted
        fill_block(0, 1'b1, 16'h0BAD, 32'hDEAD, 1'b1);
        run_cmd(2, 3'b000, 1'b1, 16'h1111, 16'hFFFF, 32'd1, 32'd1, 1, 1'b0, "R12");

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule